// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one converter operation each time it receives an already decoded command. A command may ask for a conversion with a short or a long acquisition, a calibration, or a conversion followed by power-down. A conversion is an acquisition window followed by a 14-step binary search. Each step sets one trial bit, starting at the MSB. The trial word is compared with a digital target code that stands in for the analog comparator. The bit is kept when the trial word is at or below the target, so the search settles on the target code itself.

The steps are timed in one of two ways. In serial-clock mode every step happens on a falling edge of the serial clock, counted from the command. In internal mode a free-running divided tick times the steps, the result waits in a holding register, and the serial clock only shifts the result out. The strobe output marks the conversion in a way that depends on the mode. It also has a polarity of its own during calibration. The serial data output and the strobe come with separate output-enable signals so that a pad ring can tri-state them.

All inputs are synchronous to `clk`. The serial clock is sampled as a level, and its falling edges are found inside the block.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the block is idle and in internal mode with a bipolar format and short acquisition. `strb` is 1, `dout` is 0 and `pwr_dn` is 0.
- R2: Take a serial-clock-mode command with `cmd_op`=2'b00 (short acquisition, 5 clocks). Counting falling `sclk` edges from the command, `strb` is 1 only between falls 7 and 8. The MSB appears on `dout` at fall 8, and the LSB at fall 21. Falls 22 to 24 give 0, and the 24-fall frame then ends.
- R3: With `cmd_op`=2'b11 (long acquisition, 13 clocks) in serial-clock mode, the same sequence occurs 8 falls later. The strobe is high between falls 15 and 16, the MSB appears at fall 16, the LSB at fall 29, and the frame ends at fall 32.
- R4: `dout_oe` equals the inverse of `cs_n`. In serial-clock mode `strb_oe` is 0 while `cs_n` is 1. In internal mode `strb_oe` is always 1.
- R5: An internal-mode command (`cmd_intclk`=1) drives `strb` low at once. `strb` rises after acquisition plus 14 ticks of `ICLK_DIV` clocks each. At that moment `dout` holds the MSB. The next 13 falling `sclk` edges give the remaining bits, and every later fall gives 0.
- R6: The search settles on `cmp_target`. With `cmd_unipolar`=1 the output word is that code (straight binary). With `cmd_unipolar`=0 the output word is the code with its MSB inverted (two's complement). Words are sent MSB first.
- R7: In serial-clock mode, `sclk` falls while `cs_n` is 1 are ignored. After `cs_n` returns low, the frame continues from the fall count it had reached.
- R8: A command with `cmd_op`=2'b01 calibrates for `CAL_LEN` events. In internal mode the events are ticks, `strb` is low during calibration and rises at the end. In serial-clock mode the events are `sclk` falls, `strb` is high during calibration and falls at the end.
- R9: `shdn_n` low aborts any operation and raises `pwr_dn`. The block then rests at the idle strobe level of its mode: 1 in internal mode, 0 in serial-clock mode. Commands are ignored while `shdn_n` is low. A new command also aborts a calibration that is running.
- R10: A command with `cmd_op`=2'b10 converts using the acquisition length of the previous conversion. It sets `pwr_dn` when its frame ends, and the next command clears `pwr_dn`.
- R11: A command that arrives during a conversion aborts that conversion and starts a new frame with fall count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the internal tick |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Active-low hardware shutdown |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is present |
| cmd_unipolar | input | 1 | 1 = straight binary output, 0 = two's complement |
| cmd_intclk | input | 1 | 1 = internal tick timing, 0 = serial-clock timing |
| cmd_op | input | 2 | 00 short conversion, 01 calibrate, 10 power-down conversion, 11 long conversion |
| cmp_target | input | W | Code the digital comparator compares trial words against |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout` |
| strb | output | 1 | Strobe level |
| strb_oe | output | 1 | Drive enable for `strb` |
| pwr_dn | output | 1 | Converter is powered down (software or hardware) |

## Verification
The assertions assume that `cmp_target` changes only in the same cycle as an accepted command. This lets the kept part of the search word never exceed the target. They also assume that `cmd_valid` is a single-cycle pulse. The stimulus sets the target and the command fields together on one falling `clk` edge and clears `cmd_valid` one cycle later. It holds `sclk` low through each command and through internal conversions. Each serial-clock high and low phase lasts several `clk` cycles, so every fall is seen exactly once.

// File: rtl/sar_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: operation codes are the two mode bits of the decoded command.
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_CAL  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_SHORT = 2'b00,
        OP_CAL   = 2'b01,
        OP_PDOWN = 2'b10,
        OP_LONG  = 2'b11
    } seq_op_t;
endpackage

// File: rtl/sar_seq_events.sv
// Event source: finds selected falling edges of the sampled serial clock
// and produces the free-running internal step tick.
// Assumes: sclk is synchronous to clk and each level lasts at least one cycle.
module sar_seq_events #(
    parameter int ICLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_fall,
    output logic itick
);
    logic sclk_q;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_fall = sclk_q & ~sclk & ~cs_n;

    generate
        if (ICLK_DIV <= 1) begin : g_nodiv
            assign itick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(ICLK_DIV);
            localparam logic [DW-1:0] DTOP = DW'(ICLK_DIV - 1);
            logic [DW-1:0] div_q;

            // Divide clk down to the internal step rate.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == DTOP) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign itick = (div_q == DTOP);

            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                itick |=> !itick);
        end
    endgenerate
endmodule

// File: rtl/sar_seq_approx.sv
// Binary-search register: one trial bit per step, MSB first. The trial bit
// is kept when the trial word is not above the target code.
// Assumes: target is stable between clear pulses.
module sar_seq_approx #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] target,
    output logic         step_bit,
    output logic [W-1:0] next_word,
    output logic         last
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] trial;

    assign trial     = acc_q | mask_q;
    assign step_bit  = (trial <= target);
    assign next_word = step_bit ? trial : acc_q;
    assign last      = mask_q[0];

    // Keep or drop the trial bit and move to the next lower bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            mask_q <= TOP_BIT;
        end else if (step) begin
            acc_q  <= next_word;
            mask_q <= mask_q >> 1;
        end
    end

    a_r6_acc_le_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(target) && !clear) |-> (acc_q <= target));
    a_r6_mask_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));
endmodule

// File: rtl/sar_seq_shift.sv
// Holding register for internal-mode results: loaded once, then shifted
// MSB first on each request, filling with zeros.
// Assumes: load and shift are never both asserted.
module sar_seq_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         dout_bit
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  sreg_q;
    logic [CW-1:0] cnt_q;

    // Load a word or shift it out while counting the bits sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= FULL;
        end else if (load) begin
            sreg_q <= load_word;
            cnt_q  <= '0;
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout_bit = sreg_q[W-1];

    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL) |-> !dout_bit);
endmodule

// File: rtl/sar_seq_top.sv
// Conversion sequencer top: takes decoded commands and runs acquisition,
// binary search, result output, calibration and power-down. Steps are
// timed by serial clock falls or by the internal tick, as the command selects.
// Assumes: cmd_valid is a one-cycle pulse; cmp_target changes only with it.
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int W         = 14,
    parameter int ACQ_SHORT = 5,
    parameter int ACQ_LONG  = 13,
    parameter int CAL_LEN   = 80000,
    parameter int ICLK_DIV  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shdn_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         cmd_valid,
    input  logic         cmd_unipolar,
    input  logic         cmd_intclk,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmp_target,
    output logic         dout,
    output logic         dout_oe,
    output logic         strb,
    output logic         strb_oe,
    output logic         pwr_dn
);
    localparam int STB_LEAD  = 2;
    localparam int TAIL      = 3;
    localparam int FRAME_MAX = ACQ_LONG + STB_LEAD + W + TAIL + 1;
    localparam int CNT_MAX   = (CAL_LEN > FRAME_MAX) ? CAL_LEN : FRAME_MAX;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CAL_N = CNT_W'(CAL_LEN);

    seq_state_t     state_q;
    logic           int_q, uni_q, long_q, pd_after_q, sw_pd_q, strb_q, ext_dout_q;
    logic [CNT_W-1:0] cnt_q, cnt_next, acq_len, stb_n, first_n, last_n, frame_n;
    logic           sclk_fall, itick, cmd_accept, busy;
    logic           ext_evt, ext_step, int_step, approx_step, approx_last, int_done;
    logic           step_bit, shift_load, shift_en, shift_bit, cal_evt, next_long;
    logic [W-1:0]   next_word, fmt_word, load_word;

    sar_seq_events #(.ICLK_DIV(ICLK_DIV)) events_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sclk_fall(sclk_fall), .itick(itick)
    );

    sar_seq_approx #(.W(W)) approx_i (
        .clk(clk), .rst_n(rst_n), .clear(cmd_accept), .step(approx_step),
        .target(cmp_target), .step_bit(step_bit), .next_word(next_word),
        .last(approx_last)
    );

    sar_seq_shift #(.W(W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(shift_load), .load_word(load_word),
        .shift(shift_en), .dout_bit(shift_bit)
    );

    // Frame landmarks, counted in falls from the command.
    always_comb begin
        acq_len  = long_q ? CNT_W'(ACQ_LONG) : CNT_W'(ACQ_SHORT);
        stb_n    = acq_len + CNT_W'(STB_LEAD);
        first_n  = stb_n + 1'b1;
        last_n   = stb_n + CNT_W'(W);
        frame_n  = last_n + CNT_W'(TAIL);
        cnt_next = cnt_q + 1'b1;
    end

    // Step and load qualifiers shared by the sequencing process.
    always_comb begin
        cmd_accept  = cmd_valid & shdn_n;
        busy        = (state_q == ST_ACQ) || (state_q == ST_CONV);
        ext_evt     = busy && !int_q && sclk_fall;
        ext_step    = ext_evt && (cnt_next >= first_n) && (cnt_next <= last_n);
        int_step    = int_q && (state_q == ST_CONV) && itick;
        approx_step = shdn_n && !cmd_valid && (ext_step || int_step);
        int_done    = int_step && approx_last;
        fmt_word    = uni_q ? next_word : {~next_word[W-1], next_word[W-2:0]};
        shift_load  = cmd_accept || (shdn_n && int_done);
        load_word   = cmd_accept ? '0 : fmt_word;
        shift_en    = int_q && (state_q == ST_IDLE) && sclk_fall && !cmd_accept;
        cal_evt     = int_q ? itick : sclk_fall;
        next_long   = (cmd_op == OP_LONG) ? 1'b1 :
                      (cmd_op == OP_SHORT) ? 1'b0 : long_q;
    end

    // Operation sequencing, strobe and serial-mode data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            int_q      <= 1'b1;
            uni_q      <= 1'b0;
            long_q     <= 1'b0;
            pd_after_q <= 1'b0;
            sw_pd_q    <= 1'b0;
            strb_q     <= 1'b1;
            ext_dout_q <= 1'b0;
            cnt_q      <= '0;
        end else if (!shdn_n) begin
            state_q    <= ST_IDLE;
            strb_q     <= int_q;
            pd_after_q <= 1'b0;
            ext_dout_q <= 1'b0;
            cnt_q      <= '0;
        end else if (cmd_valid) begin
            int_q      <= cmd_intclk;
            uni_q      <= cmd_unipolar;
            long_q     <= next_long;
            sw_pd_q    <= 1'b0;
            pd_after_q <= (cmd_op == OP_PDOWN);
            ext_dout_q <= 1'b0;
            cnt_q      <= '0;
            if (cmd_op == OP_CAL) begin
                state_q <= ST_CAL;
                strb_q  <= ~cmd_intclk;
            end else begin
                state_q <= ST_ACQ;
                strb_q  <= 1'b0;
            end
        end else begin
            unique case (state_q)
                ST_ACQ, ST_CONV: begin
                    if (!int_q) begin
                        if (sclk_fall) begin
                            cnt_q  <= cnt_next;
                            strb_q <= (cnt_next == stb_n);
                            if (ext_step)
                                ext_dout_q <= ((cnt_next == first_n) && !uni_q) ? ~step_bit : step_bit;
                            else
                                ext_dout_q <= 1'b0;
                            if (cnt_next == first_n) state_q <= ST_CONV;
                            if (cnt_next == frame_n) begin
                                state_q    <= ST_IDLE;
                                sw_pd_q    <= pd_after_q;
                                pd_after_q <= 1'b0;
                            end
                        end
                    end else if (itick) begin
                        if (state_q == ST_ACQ) begin
                            if (cnt_next == acq_len) begin
                                state_q <= ST_CONV;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_next;
                            end
                        end else if (approx_last) begin
                            state_q    <= ST_IDLE;
                            strb_q     <= 1'b1;
                            sw_pd_q    <= pd_after_q;
                            pd_after_q <= 1'b0;
                        end
                    end
                end
                ST_CAL: begin
                    if (cal_evt) begin
                        if (cnt_next == CAL_N) begin
                            state_q <= ST_IDLE;
                            strb_q  <= int_q;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign dout    = int_q ? shift_bit : ext_dout_q;
    assign dout_oe = ~cs_n;
    assign strb    = strb_q;
    assign strb_oe = int_q | ~cs_n;
    assign pwr_dn  = sw_pd_q | ~shdn_n;

    a_r5_strobe_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (int_q && busy) |-> !strb_q);
    a_r2_strobe_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_q && busy && strb_q) |-> (cnt_q == stb_n));
    a_r10_pd_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pd_q |-> (state_q == ST_IDLE));
    a_r8_cal_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAL) |-> (cnt_q < CAL_N));
    a_r9_shdn_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (state_q == ST_IDLE));
    a_r11_cmd_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && cmd_valid) |=> (((state_q == ST_ACQ) || (state_q == ST_CAL)) && (cnt_q == '0)));
endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
    localparam int W    = 14;
    localparam int CAL  = 20;
    localparam int DIV  = 2;
    localparam int ACQS = 5;
    localparam int ACQL = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0, shdn_n = 1'b1, cs_n = 1'b0, sclk = 1'b0;
    logic cmd_valid = 1'b0, cmd_unipolar = 1'b0, cmd_intclk = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [W-1:0] cmp_target = '0;
    logic dout, dout_oe, strb, strb_oe, pwr_dn;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // {internal, unipolar, long, target}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 14'h2ABC},
        {1'b0, 1'b1, 1'b0, 14'h1234},
        {1'b0, 1'b1, 1'b1, 14'h3FFF},
        {1'b0, 1'b0, 1'b1, 14'h0000},
        {1'b1, 1'b1, 1'b0, 14'h0001},
        {1'b1, 1'b0, 1'b1, 14'h3C5A},
        {1'b1, 1'b0, 1'b0, 14'h2000},
        {1'b0, 1'b1, 1'b0, 14'h2000}
    };

    always #2 clk = ~clk;

    sar_seq_top #(.W(W), .ACQ_SHORT(ACQS), .ACQ_LONG(ACQL), .CAL_LEN(CAL), .ICLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
        .cmd_valid(cmd_valid), .cmd_unipolar(cmd_unipolar), .cmd_intclk(cmd_intclk),
        .cmd_op(cmd_op), .cmp_target(cmp_target), .dout(dout), .dout_oe(dout_oe),
        .strb(strb), .strb_oe(strb_oe), .pwr_dn(pwr_dn)
    );

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic fall();
        @(negedge clk) sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic ic, input logic uni, input logic [1:0] op, input logic [W-1:0] tgt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_intclk = ic; cmd_unipolar = uni; cmd_op = op; cmp_target = tgt;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [W-1:0] fmt(input logic uni, input logic [W-1:0] t);
        return uni ? t : (t ^ 14'h2000);
    endfunction

    // Serial-clock frame: falls n_from..n_to, strobe and data per fall.
    task automatic ext_frame(input int acq, input logic [W-1:0] word, input int n_from,
                             input int n_to, input string tag);
        for (int n = n_from; n <= n_to; n++) begin
            logic ed;
            fall();
            ed = (n >= acq + 3 && n <= acq + 16) ? word[13 - (n - acq - 3)] : 1'b0;
            check(int'(strb), int'(n == acq + 2), {tag, " strobe"});
            check(int'(dout), int'(ed), {tag, " data"});
        end
    endtask

    // Internal conversion: strobe window, then shifted word and zero fill.
    task automatic int_conv(input int acq, input logic [W-1:0] word);
        int c;
        check(int'(strb), 0, "R5 strobe low at start");
        c = 1;
        while (!strb && c < 400) begin
            @(negedge clk);
            c++;
        end
        check(int'(c >= (acq + 13) * DIV && c <= (acq + 14) * DIV + 1), 1, "R5 strobe rise time");
        check(int'(dout), int'(word[13]), "R5/R6 msb at rise");
        for (int i = 12; i >= 0; i--) begin
            fall();
            check(int'(dout), int'(word[i]), "R5/R6 shifted bit");
        end
        for (int k = 0; k < 2; k++) begin
            fall();
            check(int'(dout), 0, "R5 zero fill");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(int'(strb), 1, "R1 strobe");
        check(int'(dout), 0, "R1 data");
        check(int'(pwr_dn), 0, "R1 power");
        check(int'(strb_oe), 1, "R1 strobe drive");
        // R4 internal mode: strobe driven with select high
        cs_n = 1'b1;
        @(negedge clk);
        check(int'(dout_oe), 0, "R4 data hiz");
        check(int'(strb_oe), 1, "R4 internal strobe driven");
        cs_n = 1'b0;
        @(negedge clk);
        check(int'(dout_oe), 1, "R4 data driven");

        // Vector table: R2, R3, R5, R6
        for (int v = 0; v < 8; v++) begin
            logic ic, uni, lng;
            logic [W-1:0] t;
            int acq;
            {ic, uni, lng, t} = VEC[v];
            acq = lng ? ACQL : ACQS;
            send(ic, uni, lng ? 2'b11 : 2'b00, t);
            if (ic) int_conv(acq, fmt(uni, t));
            else    ext_frame(acq, fmt(uni, t), 1, acq + 19, lng ? "R3/R6" : "R2/R6");
        end

        // R7: select high freezes the serial-clock frame
        send(1'b0, 1'b1, 2'b00, 14'h0F0F);
        ext_frame(ACQS, 14'h0F0F, 1, 4, "R7 before");
        cs_n = 1'b1;
        @(negedge clk);
        check(int'(strb_oe), 0, "R4 external strobe hiz");
        check(int'(dout_oe), 0, "R4 data hiz");
        for (int k = 0; k < 6; k++) fall();
        cs_n = 1'b0;
        ext_frame(ACQS, 14'h0F0F, 5, ACQS + 19, "R7 after");

        // R11: new command aborts a conversion
        send(1'b0, 1'b1, 2'b00, 14'h1111);
        for (int k = 0; k < 10; k++) fall();
        send(1'b0, 1'b1, 2'b11, 14'h2222);
        ext_frame(ACQL, 14'h2222, 1, ACQL + 19, "R11 restart");

        // R8: internal calibration
        send(1'b1, 1'b0, 2'b01, 14'h0000);
        check(int'(strb), 0, "R8 internal cal strobe low");
        begin
            int c = 1;
            while (!strb && c < 400) begin
                @(negedge clk);
                c++;
            end
            check(int'(c >= (CAL - 1) * DIV && c <= CAL * DIV + 1), 1, "R8 internal cal length");
        end
        // R8: serial-clock calibration
        send(1'b0, 1'b0, 2'b01, 14'h0000);
        check(int'(strb), 1, "R8 external cal strobe high");
        for (int k = 0; k < CAL - 1; k++) fall();
        check(int'(strb), 1, "R8 external cal still running");
        fall();
        check(int'(strb), 0, "R8 external cal end");

        // R9: shutdown aborts an internal calibration; commands ignored
        send(1'b1, 1'b0, 2'b01, 14'h0000);
        repeat (5) @(negedge clk);
        check(int'(strb), 0, "R9 cal running");
        shdn_n = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(strb), 1, "R9 shutdown idle strobe");
        check(int'(pwr_dn), 1, "R9 shutdown power");
        send(1'b1, 1'b1, 2'b00, 14'h0000);
        repeat (3) @(negedge clk);
        check(int'(strb), 1, "R9 command ignored in shutdown");
        shdn_n = 1'b1;
        @(negedge clk);
        check(int'(pwr_dn), 0, "R9 shutdown released");
        // R9: command aborts a serial-clock calibration
        send(1'b0, 1'b0, 2'b01, 14'h0000);
        for (int k = 0; k < 3; k++) fall();
        send(1'b0, 1'b1, 2'b00, 14'h0777);
        check(int'(strb), 0, "R9 cal aborted by command");
        ext_frame(ACQS, 14'h0777, 1, ACQS + 19, "R9 frame after abort");

        // R10: power-down conversion keeps the long acquisition
        send(1'b0, 1'b1, 2'b11, 14'h0100);
        ext_frame(ACQL, 14'h0100, 1, ACQL + 19, "R3 long before power-down");
        send(1'b0, 1'b1, 2'b10, 14'h0ABC);
        ext_frame(ACQL, 14'h0ABC, 1, 10, "R10 power-down frame");
        check(int'(pwr_dn), 0, "R10 awake during frame");
        ext_frame(ACQL, 14'h0ABC, 11, ACQL + 19, "R10 power-down frame");
        @(negedge clk);
        check(int'(pwr_dn), 1, "R10 powered down after frame");
        send(1'b0, 1'b1, 2'b00, 14'h0005);
        check(int'(pwr_dn), 0, "R10 wake on command");
        ext_frame(ACQS, 14'h0005, 1, ACQS + 19, "R2 frame after wake");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule